// File: doc/BRIEF.md
# Two-Bank Asynchronous SRAM Access Sequencer

This block turns single-cycle requests from a synchronous client into timed access cycles on two external asynchronous static RAM banks. The banks share one address bus and one tristate data bus. The lowest bit of the request address picks the bank, and the remaining bits go out on the shared address bus. The controller then steps through a multicycle sequence whose phase lengths are set by parameters counted in clock cycles.

A write runs in three phases. First, address, chip enable and write data are driven for a setup phase. Next, the write strobe is raised for the pulse phase. Last, everything is held for a hold phase before it is released. A read raises only the chip enable and leaves the controller's data driver off. After a fixed number of cycles the controller captures the returned word. When a write follows a read at once, a turnaround wait keeps the controller off the bus while the bank's output driver switches off. Every control pin leaves a flip-flop, so no strobe can glitch and no clock is ever gated.

The client sees a `req_ready` level that is high only while the controller is idle. A one-cycle `rsp_done` pulse marks the end of each access. Reads return their word on `rsp_rdata`, which keeps that value until the next read completes.

Top module: `sram_bank_ctrl`

## Requirements
- R1: A request whose address bit 0 is 0 raises only `mem_ce[0]`, and a request whose bit 0 is 1 raises only `mem_ce[1]`. `mem_addr` carries request address bits [ADDR_W-1:1], and at most one enable bit is high in any cycle.
- R2: While `rst` is high and in the first cycle after it, `mem_ce`, `mem_we`, `mem_dq_oe` and `rsp_done` are 0 and `req_ready` is 1.
- R3: On a write, `mem_ce`, `mem_addr`, `mem_dq_out` and `mem_dq_oe` are all active for exactly SETUP_CYC cycles before `mem_we` rises.
- R4: `mem_we` stays high for exactly PULSE_CYC consecutive cycles, and it is high only while an enable bit and `mem_dq_oe` are both high.
- R5: After `mem_we` falls, enable, address, write data and `mem_dq_oe` stay active for exactly HOLD_CYC cycles and then drop together.
- R6: `mem_addr` does not change while an enable is high, and `mem_dq_out` does not change while `mem_dq_oe` is high.
- R7: On a read, the selected enable stays high for READ_CYC cycles while `mem_dq_oe` and `mem_we` stay low. The word present on `mem_dq_in` in the last of those cycles appears on `rsp_rdata` together with `rsp_done`.
- R8: `rsp_done` is a single-cycle pulse. For an access that starts at once, it arrives SETUP_CYC+PULSE_CYC+HOLD_CYC+1 falling edges after the accepting edge for a write, and READ_CYC+1 for a read. `req_valid` is taken only while `req_ready` is high, and a request raised during an access is dropped.
- R9: A write accepted at the first opportunity after a read waits TURN_CYC extra cycles, so the data bus stays undriven for TURN_CYC+1 cycles after the read enable falls. In all cases, `mem_dq_oe` never rises within TURN_CYC cycles of a read enable falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; bit 0 selects the bank |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | High while idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last read word |
| mem_addr | output | ADDR_W-1 | Shared address bus to both banks |
| mem_ce | output | 2 | Per-bank chip enable, active high |
| mem_we | output | 1 | Shared write strobe, active high |
| mem_dq_out | output | DATA_W | Value driven onto the shared data bus |
| mem_dq_oe | output | 1 | Output enable of the data-bus pad driver |
| mem_dq_in | input | DATA_W | Value sampled from the shared data bus |

## Verification
The assertions watch the pin rules in every cycle: a single enable at a time, a strobe only inside an enabled and driven window, and minimum setup, pulse and hold lengths counted by the checker. They also cover bus stability during an access, a done pulse of one cycle, and the minimum turnaround gap before the data driver turns on. Only the bench's scenarios can show the exact phase lengths and end-to-end latencies. They also show that data reaches the bank selected by the address bit, that read data comes back from the right bank, and that a request raised mid-access is dropped rather than deferred.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_SETUP = 3'd2,
        ST_PULSE = 3'd3,
        ST_HOLD  = 3'd4,
        ST_READ  = 3'd5
    } sbc_state_e;

    function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic lsb);
        bank_onehot = lsb ? 2'b10 : 2'b01;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        max_u = (a > b) ? a : b;
    endfunction

    function automatic logic state_drives(input sbc_state_e s);
        state_drives = (s == ST_SETUP) || (s == ST_PULSE) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/sbc_phase_cnt.sv
`timescale 1ns/1ps
module sbc_phase_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sbc_turn_guard.sv
`timescale 1ns/1ps
module sbc_turn_guard #(
    parameter int unsigned TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic clear
);
    localparam int unsigned TW = $clog2(TURN_CYC + 1);

    logic [TW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (arm) begin
            wait_q <= TW'(TURN_CYC);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign clear = (wait_q == '0);
endmodule

// File: rtl/sram_bank_ctrl.sv
`timescale 1ns/1ps
module sram_bank_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned READ_CYC  = 2,
    parameter int unsigned TURN_CYC  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ADDR_W-2:0]    mem_addr,
    output logic [1:0]           mem_ce,
    output logic                 mem_we,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in
);
    localparam int unsigned MEM_AW  = ADDR_W - 1;
    localparam int unsigned CNT_MAX = max_u(max_u(SETUP_CYC, PULSE_CYC), max_u(HOLD_CYC, READ_CYC));
    localparam int unsigned CNT_W   = max_u($clog2(CNT_MAX + 1), 1);

    sbc_state_e         state_q, state_n;
    logic               accept, finish, rd_finish;
    logic               ph_load, ph_last, bus_clear;
    logic [CNT_W-1:0]   ph_val;
    logic               bank_q, bank_n;
    logic [MEM_AW-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q, rdata_q;
    logic [1:0]         ce_q;
    logic               we_q, oe_q, done_q;

    sbc_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    sbc_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk   (clk),
        .rst   (rst),
        .arm   (rd_finish),
        .clear (bus_clear)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign bank_n = accept ? req_addr[0] : bank_q;

    always_comb begin
        state_n   = state_q;
        ph_load   = 1'b0;
        ph_val    = '0;
        finish    = 1'b0;
        rd_finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_n = ST_READ;
                        ph_load = 1'b1;
                        ph_val  = CNT_W'(READ_CYC - 1);
                    end else if (!bus_clear) begin
                        state_n = ST_TURN;
                    end else begin
                        state_n = ST_SETUP;
                        ph_load = 1'b1;
                        ph_val  = CNT_W'(SETUP_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                if (bus_clear) begin
                    state_n = ST_SETUP;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (ph_last) begin
                    state_n = ST_PULSE;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (ph_last) begin
                    state_n = ST_HOLD;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (ph_last) begin
                    state_n = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_READ: begin
                if (ph_last) begin
                    state_n   = ST_IDLE;
                    finish    = 1'b1;
                    rd_finish = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Pin registers are loaded from the next-state decode so every pin is a flop output.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bank_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ce_q    <= '0;
            we_q    <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= finish;
            bank_q  <= bank_n;
            if (accept) begin
                addr_q  <= req_addr[ADDR_W-1:1];
                wdata_q <= req_wdata;
            end
            if (rd_finish) begin
                rdata_q <= mem_dq_in;
            end
            ce_q <= (state_drives(state_n) || state_n == ST_READ) ? bank_onehot(bank_n) : 2'b00;
            we_q <= (state_n == ST_PULSE);
            oe_q <= state_drives(state_n);
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_done   = done_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_ce     = ce_q;
    assign mem_we     = we_q;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = oe_q;
endmodule

// File: rtl/sbc_checker.sv
`timescale 1ns/1ps
module sbc_checker #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned TURN_CYC  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-2:0] mem_addr,
    input logic [1:0]        mem_ce,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              rsp_done
);
    logic [7:0] setup_run, pulse_run, hold_run, gap_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_run <= '0;
            pulse_run <= '0;
            hold_run  <= '0;
            gap_run   <= 8'hFF;
        end else begin
            setup_run <= (mem_dq_oe && !mem_we && setup_run != 8'hFF) ? setup_run + 1'b1 :
                         (mem_dq_oe && !mem_we) ? setup_run : 8'd0;
            pulse_run <= (mem_we && pulse_run != 8'hFF) ? pulse_run + 1'b1 :
                         mem_we ? pulse_run : 8'd0;
            hold_run  <= mem_we ? 8'd0 :
                         (mem_dq_oe && hold_run != 8'hFF) ? hold_run + 1'b1 :
                         mem_dq_oe ? hold_run : 8'd0;
            gap_run   <= (mem_ce != 2'b00 && !mem_dq_oe) ? 8'd0 :
                         (gap_run != 8'hFF) ? gap_run + 1'b1 : gap_run;
        end
    end

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(mem_ce)); // R1
    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_ce != 2'b00 && mem_dq_oe)); // R4
    AST_SETUP_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> (setup_run >= 8'(SETUP_CYC))); // R3
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        (!mem_we && pulse_run != 8'd0) |-> (pulse_run >= 8'(PULSE_CYC))); // R4
    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> (hold_run >= 8'(HOLD_CYC))); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_ce != 2'b00 && $past(mem_ce != 2'b00)) |-> $stable(mem_addr)); // R6
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R6
    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (mem_ce != 2'b00 && !mem_dq_oe) |-> !mem_we); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R8
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (gap_run >= 8'(TURN_CYC))); // R9
endmodule

bind sram_bank_ctrl sbc_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC)
) u_sbc_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_ce     (mem_ce),
    .mem_we     (mem_we),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_done   (rsp_done)
);

// File: tb/test_sram_bank_ctrl.sv
`timescale 1ns/1ps
module test_sram_bank_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int S  = 2;
    localparam int P  = 3;
    localparam int H  = 1;
    localparam int RC = 2;
    localparam int T  = 1;
    localparam int NV = 12;

    // {write, address, write data or expected read data}
    localparam logic [24:0] VEC [0:NV-1] = '{
        {1'b0, 8'h03, 16'h1003},
        {1'b1, 8'h10, 16'hA5A5},
        {1'b1, 8'h11, 16'h5A5A},
        {1'b0, 8'h10, 16'hA5A5},
        {1'b1, 8'h20, 16'h1234},
        {1'b0, 8'h11, 16'h5A5A},
        {1'b0, 8'h20, 16'h1234},
        {1'b1, 8'hFF, 16'hBEEF},
        {1'b1, 8'hFE, 16'hCAFE},
        {1'b0, 8'hFF, 16'hBEEF},
        {1'b0, 8'hFE, 16'hCAFE},
        {1'b0, 8'h21, 16'h1021}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done, mem_we, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-2:0] mem_addr;
    logic [1:0] mem_ce;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] bank0 [0:127];
    logic [DW-1:0] bank1 [0:127];

    always #2 clk = ~clk;

    sram_bank_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .PULSE_CYC(P),
                     .HOLD_CYC(H), .READ_CYC(RC), .TURN_CYC(T)) i_sram_bank_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce(mem_ce), .mem_we(mem_we), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Bank models: only the enabled, non-driven bank returns data.
    assign mem_dq_in = (mem_ce[0] && !mem_dq_oe) ? bank0[mem_addr] :
                       (mem_ce[1] && !mem_dq_oe) ? bank1[mem_addr] : '0;

    always @(negedge mem_we) begin
        if (mem_ce[0]) bank0[mem_addr] = mem_dq_out;
        if (mem_ce[1]) bank1[mem_addr] = mem_dq_out;
    end

    // Pin monitor, sampled at falling edges.
    int s_run = 0, p_run = 0, h_run = 0, last_s = 0, last_p = 0, last_h = 0;
    int gap = 100, last_gap = 100, unstable = 0, dbl_done = 0, n_done = 0;
    bit after_we = 0, prev_oe = 0, prev_done = 0;
    logic [1:0] seen_ce = '0, prev_ce = '0;
    logic [AW-2:0] seen_addr = '0, prev_addr = '0;
    logic [DW-1:0] prev_dq = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe) begin
                if (mem_we) begin p_run++; after_we = 1; end
                else if (after_we) h_run++;
                else s_run++;
            end else if (prev_oe) begin
                last_s = s_run; last_p = p_run; last_h = h_run;
                s_run = 0; p_run = 0; h_run = 0; after_we = 0;
            end
            if (mem_ce != 2'b00 && !mem_dq_oe) gap = 0;
            else if (!mem_dq_oe) gap++;
            if (mem_dq_oe && !prev_oe) last_gap = gap;
            if (mem_ce != 2'b00) begin
                seen_ce = mem_ce; seen_addr = mem_addr;
                if (prev_ce != 2'b00 && mem_addr != prev_addr) unstable++;
            end
            if (mem_dq_oe && prev_oe && mem_dq_out != prev_dq) unstable++;
            if (rsp_done) n_done++;
            if (rsp_done && prev_done) dbl_done++;
            prev_ce = mem_ce; prev_addr = mem_addr; prev_dq = mem_dq_out;
            prev_oe = mem_dq_oe; prev_done = rsp_done;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    bit last_rd = 0;

    // Called just after a falling edge; request is taken at the next rising edge.
    task automatic run_op(input logic wr, input logic [7:0] a, input logic [15:0] d);
        int k, exp_k;
        bit turn;
        turn  = wr && last_rd;
        exp_k = wr ? (S + P + H + 1 + (turn ? T : 0)) : (RC + 1);
        check(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 16'h0;
        k = 0;
        do begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            k++;
            #1;
        end while (!rsp_done && k < 100);
        check(k == exp_k, "R8 completion latency", 32'(k), 32'(exp_k));
        check(seen_ce == (a[0] ? 2'b10 : 2'b01), "R1 bank enable", 32'(seen_ce), 32'(a[0] ? 2 : 1));
        check(seen_addr == a[7:1], "R1 shared address", 32'(seen_addr), 32'(a[7:1]));
        check(unstable == 0, "R6 bus stable", 32'(unstable), 32'd0);
        if (wr) begin
            check(last_s == S, "R3 setup cycles", 32'(last_s), 32'(S));
            check(last_p == P, "R4 strobe cycles", 32'(last_p), 32'(P));
            check(last_h == H, "R5 hold cycles", 32'(last_h), 32'(H));
            check((a[0] ? bank1[a[7:1]] : bank0[a[7:1]]) == d, "R1 data in selected bank",
                  32'(a[0] ? bank1[a[7:1]] : bank0[a[7:1]]), 32'(d));
            if (turn) check(last_gap == T + 1, "R9 turnaround gap", 32'(last_gap), 32'(T + 1));
        end else begin
            check(rsp_rdata == d, "R7 read data", 32'(rsp_rdata), 32'(d));
        end
        last_rd = !wr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ops;
        for (int i = 0; i < 128; i++) begin
            bank0[i] = 16'h1000 | 16'(2 * i);
            bank1[i] = 16'h1000 | 16'(2 * i + 1);
        end
        repeat (3) @(negedge clk);
        // R2: outputs while in reset
        check(mem_ce == 2'b00 && !mem_we && !mem_dq_oe, "R2 pins idle in reset", {29'd0, mem_ce, mem_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(mem_ce == 2'b00, "R2 no enable after reset", 32'(mem_ce), 32'd0);
        check(!mem_we && !mem_dq_oe, "R2 no strobe or drive", {30'd0, mem_we, mem_dq_oe}, 32'd0);
        check(req_ready == 1'b1, "R2 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_done == 1'b0, "R2 no done after reset", 32'(rsp_done), 32'd0);

        for (int v = 0; v < NV; v++) run_op(VEC[v][24], VEC[v][23:16], VEC[v][15:0]);
        ops = NV;

        // R8: request raised mid-access is dropped
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h30; req_wdata = 16'h7777;
        @(negedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk); #1;
        check(req_ready == 1'b0, "R8 not ready while busy", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h31; req_wdata = 16'h9999;
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        ops++;
        check(n_done == ops, "R8 one done per accepted request", 32'(n_done), 32'(ops));
        last_rd = 0;
        run_op(1'b0, 8'h31, 16'h1031);
        run_op(1'b0, 8'h30, 16'h7777);
        ops += 2;

        // R9: write after an idle gap no longer waits for turnaround
        repeat (4) @(negedge clk);
        #1;
        last_rd = 0;
        run_op(1'b1, 8'h40, 16'h4040);
        ops++;

        check(dbl_done == 0, "R8 done lasts one cycle", 32'(dbl_done), 32'd0);
        check(n_done == ops, "R8 total done pulses", 32'(n_done), 32'(ops));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule